// File: doc/BRIEF.md
# Vector-Quantizer Element Selector for Unit-Element DACs

This block chooses which unit elements of a thermometer-style DAC turn on in each sample. The DAC has `NUM_ELEM` identical elements, and the requested output level K is the number of elements that must conduct. Every element has its own small digital noise-shaping loop. The loop stores the recent quantization errors of that element and passes them through a loop filter. The result is a pre-quantization value for the element. In each cycle the block ranks these values and turns on the K elements with the largest values. Because each element's usage error is fed back, element mismatch shows up as high-pass-shaped noise and not as distortion.

Two shaping orders are available. First order uses a single-delay feedback and gives a (1 - z^-1) error transfer. Second order uses a two-tap feedback and gives (1 - z^-1)^2. Before ranking, the smallest loop-filter output of the current cycle is subtracted from every loop. This common shift keeps the stored numbers small and non-negative. It does not change which elements are chosen.

Ranking uses comparison counts. The rank of an element is the number of other elements that beat it. An element beats another when its value is strictly larger, or when the values are equal and its index is lower. An element is selected when its rank is below K. The enable vector is registered, so it appears one clock after the level is presented.

Top module: `vq_mismatch_shaper`

## Requirements
- R1: While `rst` is high, `elem_en` is all zeros and every loop error state is cleared. After release, the first selection with any order starts from all-equal values: for K=3 it enables elements 0,1,2 (`elem_en` = 8'h07).
- R2: The `elem_en` value registered at a clock edge has exactly min(K, NUM_ELEM) bits set. K is the `level` value present at that edge. The result is visible after that edge.
- R3: A `level` value above NUM_ELEM (for example 12 or 15 on the 4-bit port) enables all elements (`elem_en` = 8'hFF).
- R4: The enabled elements are the K elements whose pre-quantization value y_i is largest. Bit i of `elem_en` drives element i.
- R5: When values are equal, the lower element index is chosen first.
- R6: With `order_sel` = 0 (first order), the loop-filter output of element i is t_i(n) = -e_i(n-1).
- R7: With `order_sel` = 1 (second order), the loop-filter output of element i is t_i(n) = -2·e_i(n-1) + e_i(n-2).
- R8: The pre-quantization value is y_i(n) = t_i(n) - min_j t_j(n), so at least one y is zero. The stored error is e_i(n) = x_i(n) - y_i(n), where x_i is the enable bit.
- R9: No loop error leaves the signed `ERR_W`-bit range.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| order_sel | input | 1 | Shaping order: 0 first order, 1 second order |
| level | input | 4 | Requested number of enabled elements K (0..8; larger values saturate) |
| elem_en | output | 8 | Registered element enables, bit i for element i |

## Verification
Each order is driven with a sequence of constant K=3 followed by a spread of levels (0, 1, 2, 4, 5, 8). The expected enables are worked out by hand from the loop equations. In first order, the constant level gives a plain rotation through the array. In second order, the same level gives repeated picks of the same elements, which separates the R6 feedback from the R7 feedback. The hand-worked vectors also include tie cases, where several elements share a value and only the lower-index rule (R5) selects the right bits. They also include offset cases, where the chosen elements would differ if the common minimum were handled wrongly. Saturating levels are applied straight after reset and followed by K=3. A long random run of levels and orders then checks the enabled count against the saturated level.

// File: rtl/vqms_pkg.sv
`timescale 1ns/1ps
package vqms_pkg;

    // Default array size and error width
    localparam int unsigned DEF_NUM_ELEM = 8;
    localparam int unsigned DEF_ERR_W    = 8;
    // Extra bits of the filter arithmetic over the stored error width
    localparam int unsigned ACC_GUARD    = 3;

    typedef enum logic {
        ORD_FIRST  = 1'b0,
        ORD_SECOND = 1'b1
    } shape_order_t;

    // Requested level, limited to the number of elements
    function automatic int unsigned sat_level(input int unsigned req,
                                              input int unsigned n_elem);
        return (req > n_elem) ? n_elem : req;
    endfunction

    // Bits needed to hold a count 0..n
    function automatic int unsigned count_bits(input int unsigned n);
        return $clog2(n + 1);
    endfunction

endpackage

// File: rtl/vqms_elem_loop.sv
`timescale 1ns/1ps
// One noise-shaping loop: error history and loop filter for a single element
module vqms_elem_loop
    import vqms_pkg::*;
#(
    parameter int unsigned ERR_W = DEF_ERR_W,
    parameter int unsigned ACC_W = DEF_ERR_W + ACC_GUARD
) (
    input  logic                    clk,
    input  logic                    rst,
    input  shape_order_t            order,
    input  logic                    pick,      // quantized output x_i
    input  logic signed [ACC_W-1:0] y_val,     // offset-removed value y_i
    output logic signed [ACC_W-1:0] filt_out   // loop-filter output t_i
);

    localparam logic signed [ACC_W-1:0] ERR_MAX = ACC_W'((1 << (ERR_W - 1)) - 1);
    localparam logic signed [ACC_W-1:0] ERR_MIN = -ACC_W'(1 << (ERR_W - 1));

    logic signed [ERR_W-1:0] err_d1, err_d2;
    logic signed [ACC_W-1:0] err_now;
    logic signed [ACC_W-1:0] d1_ext, d2_ext;
    logic signed [ACC_W-1:0] pick_ext;

    assign pick_ext = pick ? ACC_W'(1) : '0;
    assign err_now  = pick_ext - y_val;

    always_ff @(posedge clk) begin
        if (rst) begin
            err_d1 <= '0;
            err_d2 <= '0;
        end else begin
            err_d1 <= ERR_W'(err_now);
            err_d2 <= err_d1;
        end
    end

    assign d1_ext = {{(ACC_W-ERR_W){err_d1[ERR_W-1]}}, err_d1};
    assign d2_ext = {{(ACC_W-ERR_W){err_d2[ERR_W-1]}}, err_d2};

    always_comb begin
        unique case (order)
            ORD_SECOND: filt_out = d2_ext - (d1_ext + d1_ext);
            default:    filt_out = -d1_ext;
        endcase
    end

    // R9: new error must fit the stored width
    p_no_overflow_r9: assert property (@(posedge clk) disable iff (rst)
        (err_now <= ERR_MAX) && (err_now >= ERR_MIN));

endmodule

// File: rtl/vqms_floor.sv
`timescale 1ns/1ps
// Common offset removal: subtract the smallest filter output from every loop
module vqms_floor #(
    parameter int unsigned N = 8,
    parameter int unsigned W = 11
) (
    input  logic                clk,
    input  logic                rst,
    input  logic signed [W-1:0] filt [N],
    output logic signed [W-1:0] y_val [N]
);

    logic signed [W-1:0] floor_v;
    logic [N-1:0]        at_floor;

    always_comb begin
        floor_v = filt[0];
        for (int i = 1; i < N; i++) begin
            if (filt[i] < floor_v) floor_v = filt[i];
        end
    end

    for (genvar i = 0; i < N; i++) begin : g_sub
        assign y_val[i]    = filt[i] - floor_v;
        assign at_floor[i] = (y_val[i] == '0);
    end

    // R8: after offset removal at least one element sits at zero
    p_floor_hit_r8: assert property (@(posedge clk) disable iff (rst)
        at_floor != '0);

endmodule

// File: rtl/vqms_rank.sv
`timescale 1ns/1ps
// Comparison-count ranking: rank = number of elements that beat this one
module vqms_rank #(
    parameter int unsigned N   = 8,
    parameter int unsigned W   = 11,
    parameter int unsigned CNT = 4
) (
    input  logic                clk,
    input  logic                rst,
    input  logic signed [W-1:0] y_val [N],
    input  logic [CNT-1:0]      k_eff,
    output logic [N-1:0]        sel
);

    logic [CNT-1:0] rank [N];

    for (genvar i = 0; i < N; i++) begin : g_rank
        always_comb begin
            rank[i] = '0;
            for (int j = 0; j < N; j++) begin
                if (j != i) begin
                    if ((y_val[j] > y_val[i]) ||
                        ((y_val[j] == y_val[i]) && (j < i)))
                        rank[i] = rank[i] + CNT'(1);
                end
            end
        end
        assign sel[i] = (rank[i] < k_eff);
    end

    // Order check: no unselected element may exceed a selected one
    logic order_ok;
    always_comb begin
        order_ok = 1'b1;
        for (int a = 0; a < N; a++) begin
            for (int b = 0; b < N; b++) begin
                if (sel[a] && !sel[b] && (y_val[b] > y_val[a])) order_ok = 1'b0;
            end
        end
    end

    // R4: chosen elements hold the largest values
    p_largest_first_r4: assert property (@(posedge clk) disable iff (rst)
        order_ok);

    // R2: ranking picks exactly k_eff elements
    p_pick_count_r2: assert property (@(posedge clk) disable iff (rst)
        $countones(sel) == int'(k_eff));

endmodule

// File: rtl/vq_mismatch_shaper.sv
`timescale 1ns/1ps
module vq_mismatch_shaper
    import vqms_pkg::*;
#(
    parameter int unsigned NUM_ELEM = DEF_NUM_ELEM,
    parameter int unsigned ERR_W    = DEF_ERR_W
) (
    input  logic                                   clk,
    input  logic                                   rst,
    input  logic                                   order_sel,
    input  logic [$clog2(NUM_ELEM+1)-1:0]          level,
    output logic [NUM_ELEM-1:0]                    elem_en
);

    localparam int unsigned LVL_W = count_bits(NUM_ELEM);
    localparam int unsigned ACC_W = ERR_W + ACC_GUARD;

    shape_order_t            order;
    logic [LVL_W-1:0]        k_eff;
    logic signed [ACC_W-1:0] filt  [NUM_ELEM];
    logic signed [ACC_W-1:0] y_val [NUM_ELEM];
    logic [NUM_ELEM-1:0]     sel;

    assign order = shape_order_t'(order_sel);
    assign k_eff = LVL_W'(sat_level(int'(level), NUM_ELEM));

    for (genvar i = 0; i < NUM_ELEM; i++) begin : g_loop
        vqms_elem_loop #(
            .ERR_W (ERR_W),
            .ACC_W (ACC_W)
        ) u_loop (
            .clk      (clk),
            .rst      (rst),
            .order    (order),
            .pick     (sel[i]),
            .y_val    (y_val[i]),
            .filt_out (filt[i])
        );
    end

    vqms_floor #(
        .N (NUM_ELEM),
        .W (ACC_W)
    ) u_floor (
        .clk   (clk),
        .rst   (rst),
        .filt  (filt),
        .y_val (y_val)
    );

    vqms_rank #(
        .N   (NUM_ELEM),
        .W   (ACC_W),
        .CNT (LVL_W)
    ) u_rank (
        .clk   (clk),
        .rst   (rst),
        .y_val (y_val),
        .k_eff (k_eff),
        .sel   (sel)
    );

    always_ff @(posedge clk) begin
        if (rst) elem_en <= '0;
        else     elem_en <= sel;
    end

    // R1: first edge after release still shows the cleared output
    p_reset_clear_r1: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> (elem_en == '0));

    // R2: registered enable count follows the saturated level one cycle later
    p_count_follows_r2: assert property (@(posedge clk) disable iff (rst)
        !rst |=> ($countones(elem_en) == int'($past(k_eff))));

    // R3: oversize level turns every element on
    p_saturate_r3: assert property (@(posedge clk) disable iff (rst)
        (int'(level) > NUM_ELEM) |=> (&elem_en));

endmodule

// File: tb/sim_vq_mismatch_shaper.sv
`timescale 1ns/1ps
module sim_vq_mismatch_shaper;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       order_sel = 1'b0;
    logic [3:0] level = 4'd0;
    logic [7:0] elem_en;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 0;

    always #10 clk = ~clk;   // 50 MHz

    vq_mismatch_shaper u0 (
        .clk       (clk),
        .rst       (rst),
        .order_sel (order_sel),
        .level     (level),
        .elem_en   (elem_en)
    );

    // Vector: {reset_before, order, level[3:0], expected enables[7:0]}
    typedef logic [13:0] vec_t;
    localparam int NV = 15;
    localparam vec_t TBL [NV] = '{
        // first order (R6), hand-worked from R4/R5/R8
        {1'b1, 1'b0, 4'd3, 8'h07},
        {1'b0, 1'b0, 4'd3, 8'h38},
        {1'b0, 1'b0, 4'd3, 8'hC1},
        {1'b0, 1'b0, 4'd3, 8'h0E},
        {1'b0, 1'b0, 4'd8, 8'hFF},
        {1'b0, 1'b0, 4'd0, 8'h00},
        {1'b0, 1'b0, 4'd5, 8'hF1},
        {1'b0, 1'b0, 4'd1, 8'h02},
        {1'b0, 1'b0, 4'd2, 8'h0C},
        // second order (R7)
        {1'b1, 1'b1, 4'd3, 8'h07},
        {1'b0, 1'b1, 4'd3, 8'h38},
        {1'b0, 1'b1, 4'd3, 8'hC8},
        {1'b0, 1'b1, 4'd3, 8'hD0},
        {1'b0, 1'b1, 4'd4, 8'h27},
        {1'b0, 1'b1, 4'd0, 8'h00}
    };

    task automatic check(input string req, input logic [7:0] act,
                         input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: got %h, want %h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        rst = 1'b1;
        @(negedge clk);
        @(negedge clk);
        check("R1 enables low in reset", elem_en, 8'h00);
        rst = 1'b0;
    endtask

    // Drive at a falling edge; result is valid at the next falling edge
    task automatic apply(input logic ord, input logic [3:0] k);
        order_sel = ord;
        level     = k;
        @(negedge clk);
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    endtask

    initial begin
        @(negedge clk);
        for (int v = 0; v < NV; v++) begin
            if (TBL[v][13]) do_reset();
            apply(TBL[v][12], TBL[v][11:8]);
            n_chk++;
            if (elem_en !== TBL[v][7:0]) begin
                n_bad++;
                $display("FAIL R4/R5 vector %0d (order %0d, K %0d): got %h, want %h",
                         v, TBL[v][12], TBL[v][11:8], elem_en, TBL[v][7:0]);
            end
        end

        // R3: oversize levels saturate; then all-equal state gives R5 tie order
        do_reset();
        apply(1'b0, 4'd12);
        check("R3 level 12", elem_en, 8'hFF);
        apply(1'b0, 4'd15);
        check("R3 level 15", elem_en, 8'hFF);
        apply(1'b0, 4'd3);
        check("R5 ties after full use", elem_en, 8'h07);

        // R1: reset mid-stream clears history (second order restarts at 07)
        apply(1'b1, 4'd6);
        do_reset();
        apply(1'b1, 4'd3);
        check("R1 history cleared", elem_en, 8'h07);

        // R2: random levels and orders, count equals saturated level
        for (int r = 0; r < 200; r++) begin
            logic [3:0] k;
            int         want;
            k = 4'($urandom_range(0, 15));
            apply(1'($urandom_range(0, 1)), k);
            want = (k > 8) ? 8 : int'(k);
            n_chk++;
            if ($countones(elem_en) != want) begin
                n_bad++;
                $display("FAIL R2 step %0d: got %0d enabled, want %0d",
                         r, $countones(elem_en), want);
            end
        end

        done = 1;
        summary();
        $finish;
    end

    initial begin
        #(20 * 100000);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: run did not finish");
            summary();
            $finish;
        end
    end

endmodule